// File: doc/BRIEF.md
# Dual-Slope Converter Phase Sequencer

This block is the digital half of a dual-slope integrating analog-to-digital converter. It steps the external analog section through a repeating four-phase cycle: auto zero, then integrate, then deintegrate, then integrator zero, and then back to auto zero. While the input is integrated it holds the chosen integration window. During deintegrate it counts system ticks until the comparator reports a zero crossing. The final count is the conversion result.

The integration window comes from an eight-entry table of line-frequency multiples, selected by a 3-bit code. It is converted to tick counts at elaboration from the system-tick rate. The system tick runs at one quarter of the input clock. In the following auto zero phase, the result of the last conversion is shifted out serially with its own bit clock, and an active-low data-ready strobe marks it. A chip-select input controls the pad enable of the serial pins. A sleep input parks the sequencer, powers down the analog converter and withdraws the oscillator enable.

Top module: `dsc_sequencer`

## Requirements
- R1: The phase outputs az_en, int_en, deint_en and iz_en are one-hot while running, and always follow the order auto zero, integrate, deintegrate, integrator zero, auto zero.
- R2: Every phase change happens on a system tick, once every 4 input clocks. Auto zero lasts AZ_TICKS ticks and integrator zero lasts IZ_TICKS ticks.
- R3: Integrate lasts N ticks, where N = floor((SYS_HZ*k + 30)/60). The value of k comes from tint_sel, with bit 2 as the most significant bit: 000→1, 001→2, 010→3, 011→4, 100→6, 101→10, 110→12, 111→18.
- R4: tint_sel is sampled only on the tick that ends auto zero. A change made during integrate has no effect on the integrate phase in progress, and takes effect in the next one.
- R5: The comparator input passes through a two-flop synchronizer. If the synchronized comparator is first seen on the K-th tick of deintegrate, then the result is K-1 and deintegrate lasts K ticks.
- R6: If no crossing is seen, deintegrate stops after 2N ticks with result 2N and result_ovf = 1. A conversion that ends on a crossing clears result_ovf to 0.
- R7: data_ready_n is low for the whole auto zero phase once a result exists. It is high in every other phase, and high in the first auto zero after reset.
- R8: ser_clk idles high. From the tick that starts auto zero, 24 result bits are sent MSB first. On each bit, ser_clk falls while ser_data changes, and ser_clk rises one tick later, so one bit takes 2 ticks.
- R9: out_en, the pad enable for data_ready_n, ser_data and ser_clk, equals the inverse of sel_n delayed by one input clock.
- R10: During and after reset, all phase outputs are 0, data_ready_n = 1, ser_clk = 1, conv_pd = 0, osc_en = 1 and out_en = 0. Auto zero starts after INIT_TICKS ticks, which is 4*INIT_TICKS input clocks after reset is released.
- R11: A synchronized high on sleep_req ends the current phase on the next tick. All phase outputs go to 0, conv_pd goes to 1 and osc_en goes to 0, between 3 and 6 input clocks after the input changes. Releasing sleep_req restarts a full auto zero phase, which shifts out the held result again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock (crystal or external) |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| sleep_req | input | 1 | High requests power down, low runs |
| sel_n | input | 1 | Active-low chip select |
| tint_sel | input | 3 | Integration-time code |
| cmp_cross | input | 1 | Comparator zero-crossing from the analog side |
| az_en | output | 1 | Auto-zero phase control |
| int_en | output | 1 | Integrate phase control |
| deint_en | output | 1 | Deintegrate phase control |
| iz_en | output | 1 | Integrator-zero phase control |
| conv_pd | output | 1 | Power-down to the analog converter |
| osc_en | output | 1 | Oscillator enable |
| data_ready_n | output | 1 | Active-low result-available strobe |
| ser_data | output | 1 | Serial result data |
| ser_clk | output | 1 | Serial bit clock |
| out_en | output | 1 | Pad enable for the three serial-side pins |
| result_ovf | output | 1 | Last deintegrate hit its count limit |

## Verification
The bench builds the block with SYS_HZ = 630, AZ_TICKS = 50, IZ_TICKS = 6 and INIT_TICKS = 5. At this rate, codes 000 and 010 give exact half-tick values (10.5 and 31.5), so the round-half-up rule is tested directly. The longest table entry is 189 ticks, so a full conversion takes only a few thousand clocks. The short windows also let one run reach the 22-tick overflow limit, a setting change made in mid-integrate, and a sleep-and-resume.

// File: rtl/dsc_pkg.sv
`timescale 1ns/1ps
package dsc_pkg;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_OFF,
    ST_AZ,
    ST_INT,
    ST_DEINT,
    ST_IZ
  } seq_st_t;

  // Integration window in sixtieths of a second for each select code.
  function automatic int unsigned window_sixtieths(input logic [2:0] code);
    case (code)
      3'b000:  return 1;
      3'b001:  return 2;
      3'b010:  return 3;
      3'b011:  return 4;
      3'b100:  return 6;
      3'b101:  return 10;
      3'b110:  return 12;
      default: return 18;
    endcase
  endfunction

  // Tick count for a window, rounded to the nearest whole tick (halves up).
  function automatic int unsigned window_ticks(input int unsigned sys_hz,
                                               input logic [2:0] code);
    longint unsigned prod;
    prod = 64'(sys_hz) * 64'(window_sixtieths(code)) + 64'd30;
    return 32'(prod / 64'd60);
  endfunction

  // Phase output bits: [0] auto zero, [1] integrate, [2] deintegrate, [3] integrator zero.
  function automatic logic [3:0] phase_bits(input seq_st_t s);
    case (s)
      ST_AZ:    return 4'b0001;
      ST_INT:   return 4'b0010;
      ST_DEINT: return 4'b0100;
      ST_IZ:    return 4'b1000;
      default:  return 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/dsc_prescale.sv
`timescale 1ns/1ps
module dsc_prescale #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2: ticks are never back to back at a divide by 4
  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

endmodule

// File: rtl/dsc_sync.sv
`timescale 1ns/1ps
module dsc_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/dsc_phase_ctrl.sv
`timescale 1ns/1ps
module dsc_phase_ctrl
  import dsc_pkg::*;
#(
  parameter int unsigned SYS_HZ     = 1_000_000,
  parameter int unsigned W          = 24,
  parameter int unsigned AZ_TICKS   = 64,
  parameter int unsigned IZ_TICKS   = 16,
  parameter int unsigned INIT_TICKS = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         sleep_s,
  input  logic         cmp_s,
  input  logic [2:0]   tint_sel,
  output logic [3:0]   ph_q,
  output logic         conv_pd_q,
  output logic         osc_en_q,
  output logic         dv_n_q,
  output logic         ovf_q,
  output logic [W-1:0] result_q,
  output logic         shift_start,
  output logic         az_next
);
  localparam int unsigned NSEL = 8;

  seq_st_t     st_q, st_nxt;
  logic [W-1:0] tmr_q, tmr_nxt;
  logic [W-1:0] cnt_q, cnt_nxt, cnt_inc;
  logic [W-1:0] nint_q, nint_nxt;
  logic [W-1:0] res_nxt, max_cnt;
  logic         have_q, have_nxt, ovf_nxt;
  logic         running;

  // Window table built from the tick rate, one entry per select code.
  logic [W-1:0] nint_tab [NSEL];
  for (genvar g = 0; g < NSEL; g++) begin : g_tab
    assign nint_tab[g] = W'(window_ticks(SYS_HZ, 3'(g)));
  end

  assign max_cnt = nint_q << 1;
  assign cnt_inc = cnt_q + 1'b1;
  assign running = (st_q == ST_AZ) || (st_q == ST_INT) ||
                   (st_q == ST_DEINT) || (st_q == ST_IZ);

  always_comb begin
    st_nxt   = st_q;
    tmr_nxt  = tmr_q + 1'b1;
    cnt_nxt  = cnt_q;
    nint_nxt = nint_q;
    res_nxt  = result_q;
    ovf_nxt  = ovf_q;
    have_nxt = have_q;
    case (st_q)
      ST_INIT: begin
        if (tmr_q == W'(INIT_TICKS - 1)) begin
          tmr_nxt = '0;
          st_nxt  = sleep_s ? ST_OFF : ST_AZ;
        end
      end
      ST_OFF: begin
        tmr_nxt = '0;
        if (!sleep_s) st_nxt = ST_AZ;
      end
      ST_AZ: begin
        if (tmr_q == W'(AZ_TICKS - 1)) begin
          tmr_nxt  = '0;
          st_nxt   = ST_INT;
          nint_nxt = nint_tab[tint_sel];
        end
      end
      ST_INT: begin
        if (tmr_q == nint_q - 1'b1) begin
          tmr_nxt = '0;
          cnt_nxt = '0;
          st_nxt  = ST_DEINT;
        end
      end
      ST_DEINT: begin
        tmr_nxt = '0;
        if (cmp_s) begin
          res_nxt  = cnt_q;
          ovf_nxt  = 1'b0;
          have_nxt = 1'b1;
          st_nxt   = ST_IZ;
        end else begin
          cnt_nxt = cnt_inc;
          if (cnt_inc == max_cnt) begin
            res_nxt  = max_cnt;
            ovf_nxt  = 1'b1;
            have_nxt = 1'b1;
            st_nxt   = ST_IZ;
          end
        end
      end
      ST_IZ: begin
        if (tmr_q == W'(IZ_TICKS - 1)) begin
          tmr_nxt = '0;
          st_nxt  = ST_AZ;
        end
      end
      default: begin
        tmr_nxt = '0;
        st_nxt  = ST_INIT;
      end
    endcase
    if (running && sleep_s) begin
      st_nxt  = ST_OFF;
      tmr_nxt = '0;
    end
  end

  assign az_next     = (st_nxt == ST_AZ);
  assign shift_start = tick && az_next && (st_q != ST_AZ) && have_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_INIT;
      tmr_q     <= '0;
      cnt_q     <= '0;
      nint_q    <= '0;
      result_q  <= '0;
      ovf_q     <= 1'b0;
      have_q    <= 1'b0;
      ph_q      <= '0;
      conv_pd_q <= 1'b0;
      osc_en_q  <= 1'b1;
      dv_n_q    <= 1'b1;
    end else if (tick) begin
      st_q      <= st_nxt;
      tmr_q     <= tmr_nxt;
      cnt_q     <= cnt_nxt;
      nint_q    <= nint_nxt;
      result_q  <= res_nxt;
      ovf_q     <= ovf_nxt;
      have_q    <= have_nxt;
      ph_q      <= phase_bits(st_nxt);
      conv_pd_q <= (st_nxt == ST_OFF);
      osc_en_q  <= (st_nxt != ST_OFF);
      dv_n_q    <= !((st_nxt == ST_AZ) && have_nxt);
    end
  end

  // R1: integrate is entered only from auto zero
  assert_int_after_az_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(ph_q[1]) |-> $past(ph_q[0]));

  // R1: deintegrate is entered only from integrate
  assert_deint_after_int_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(ph_q[2]) |-> $past(ph_q[1]));

  // R7: the data-ready strobe is low only inside auto zero
  assert_dv_in_az_R7: assert property (@(posedge clk) disable iff (rst)
    !dv_n_q |-> ph_q[0]);

  // R6: the deintegrate count stays below its 2N limit
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DEINT) |-> (cnt_q < max_cnt));

  // R11: power down leaves every phase output low and the oscillator off
  assert_off_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    conv_pd_q |-> ((ph_q == 4'b0000) && !osc_en_q));

endmodule

// File: rtl/dsc_shift_out.sv
`timescale 1ns/1ps
module dsc_shift_out #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         start,
  input  logic         keep,
  input  logic [W-1:0] word,
  output logic         sdata_q,
  output logic         sclk_q,
  output logic         busy_q
);
  localparam int unsigned HALVES = 2 * W;
  localparam int unsigned HW     = $clog2(HALVES);

  logic [HW-1:0] half_q;
  logic [W-1:0]  sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q  <= '0;
      sh_q    <= '0;
      sdata_q <= 1'b0;
      sclk_q  <= 1'b1;
      busy_q  <= 1'b0;
    end else if (tick) begin
      if (start) begin
        busy_q  <= 1'b1;
        half_q  <= '0;
        sclk_q  <= 1'b0;
        sdata_q <= word[W-1];
        sh_q    <= word << 1;
      end else if (busy_q) begin
        if (!keep || (half_q == HW'(HALVES - 1))) begin
          busy_q <= 1'b0;
          sclk_q <= 1'b1;
        end else begin
          half_q <= half_q + 1'b1;
          if (!half_q[0]) begin
            sclk_q <= 1'b1;
          end else begin
            sclk_q  <= 1'b0;
            sdata_q <= sh_q[W-1];
            sh_q    <= sh_q << 1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/dsc_sequencer.sv
`timescale 1ns/1ps
module dsc_sequencer
  import dsc_pkg::*;
#(
  parameter int unsigned SYS_HZ      = 1_000_000,
  parameter int unsigned RES_W       = 24,
  parameter int unsigned AZ_TICKS    = 64,
  parameter int unsigned IZ_TICKS    = 16,
  parameter int unsigned INIT_TICKS  = 8,
  parameter int unsigned CLK_DIV     = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sleep_req,
  input  logic       sel_n,
  input  logic [2:0] tint_sel,
  input  logic       cmp_cross,
  output logic       az_en,
  output logic       int_en,
  output logic       deint_en,
  output logic       iz_en,
  output logic       conv_pd,
  output logic       osc_en,
  output logic       data_ready_n,
  output logic       ser_data,
  output logic       ser_clk,
  output logic       out_en,
  output logic       result_ovf
);
  logic             tick;
  logic             sleep_s, cmp_s;
  logic [3:0]       ph;
  logic [RES_W-1:0] result;
  logic             shift_start, az_next, sh_busy;
  logic             oe_q;

  dsc_prescale #(.DIV(CLK_DIV)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  dsc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sleep_req, cmp_cross}),
    .q   ({sleep_s, cmp_s})
  );

  dsc_phase_ctrl #(
    .SYS_HZ     (SYS_HZ),
    .W          (RES_W),
    .AZ_TICKS   (AZ_TICKS),
    .IZ_TICKS   (IZ_TICKS),
    .INIT_TICKS (INIT_TICKS)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .sleep_s     (sleep_s),
    .cmp_s       (cmp_s),
    .tint_sel    (tint_sel),
    .ph_q        (ph),
    .conv_pd_q   (conv_pd),
    .osc_en_q    (osc_en),
    .dv_n_q      (data_ready_n),
    .ovf_q       (result_ovf),
    .result_q    (result),
    .shift_start (shift_start),
    .az_next     (az_next)
  );

  dsc_shift_out #(.W(RES_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .start   (shift_start),
    .keep    (az_next),
    .word    (result),
    .sdata_q (ser_data),
    .sclk_q  (ser_clk),
    .busy_q  (sh_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= !sel_n;
  end

  assign out_en   = oe_q;
  assign az_en    = ph[0];
  assign int_en   = ph[1];
  assign deint_en = ph[2];
  assign iz_en    = ph[3];

  // R8: the serial word is only ever in flight during auto zero
  assert_shift_in_az_R8: assert property (@(posedge clk) disable iff (rst)
    sh_busy |-> az_en);

  // R8: while nothing is being shifted the bit clock rests high
  assert_sclk_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!sh_busy && !$past(sh_busy)) |-> ser_clk);

endmodule

// File: tb/dsc_sequencer_tb_top.sv
`timescale 1ns/1ps
module dsc_sequencer_tb_top;
  localparam int unsigned SYS_HZ = 630;
  localparam int unsigned AZ_T   = 50;
  localparam int unsigned IZ_T   = 6;
  localparam int unsigned INIT_T = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_req = 1'b0;
  logic sel_n = 1'b0;
  logic [2:0] tint_sel = 3'b100;
  logic cmp_cross = 1'b0;
  logic az_en, int_en, deint_en, iz_en, conv_pd, osc_en;
  logic data_ready_n, ser_data, ser_clk, out_en, result_ovf;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  dsc_sequencer #(
    .SYS_HZ(SYS_HZ), .RES_W(24), .AZ_TICKS(AZ_T), .IZ_TICKS(IZ_T),
    .INIT_TICKS(INIT_T)
  ) dut_i (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .sel_n(sel_n),
    .tint_sel(tint_sel), .cmp_cross(cmp_cross), .az_en(az_en),
    .int_en(int_en), .deint_en(deint_en), .iz_en(iz_en), .conv_pd(conv_pd),
    .osc_en(osc_en), .data_ready_n(data_ready_n), .ser_data(ser_data),
    .ser_clk(ser_clk), .out_en(out_en), .result_ovf(result_ovf)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_ticks(input int k);
    return (SYS_HZ * k + 30) / 60;
  endfunction

  function automatic int phases();
    return {iz_en, deint_en, int_en, az_en};
  endfunction

  task automatic t_reset();
    int n;
    bit dv_ok, sc_ok;
    repeat (3) @(negedge clk);
    chk(phases() == 0, "R10", "phases in reset", phases(), 0);
    chk(data_ready_n && ser_clk && !conv_pd && osc_en, "R10", "idle outputs",
        {data_ready_n, ser_clk, conv_pd, osc_en}, 4'b1101);
    chk(out_en == 1'b0, "R10", "out_en in reset", out_en, 0);
    rst = 1'b0;
    n = 0;
    while (!az_en) begin @(negedge clk); n++; end
    chk(n == 4 * INIT_T, "R10", "clocks to first auto zero", n, 4 * INIT_T);
    n = 0; dv_ok = 1; sc_ok = 1;
    while (az_en) begin
      n++;
      if (!data_ready_n) dv_ok = 0;
      if (!ser_clk) sc_ok = 0;
      @(negedge clk);
    end
    chk(n == 4 * AZ_T, "R2", "auto zero clocks", n, 4 * AZ_T);
    chk(dv_ok, "R7", "strobe high in first auto zero", dv_ok, 1);
    chk(sc_ok, "R8", "bit clock idle without result", sc_ok, 1);
    chk(int_en && phases() == 2, "R1", "integrate after auto zero", phases(), 2);
  endtask

  task automatic t_int(input int exp_t, input int chg_at, input logic [2:0] chg_val,
                       input string req);
    int n;
    n = 0;
    while (!int_en) @(negedge clk);
    while (int_en) begin
      n++;
      if (n == chg_at) tint_sel = chg_val;
      @(negedge clk);
    end
    chk(n == 4 * exp_t, req, "integrate clocks", n, 4 * exp_t);
    chk(phases() == 4, "R1", "deintegrate after integrate", phases(), 4);
  endtask

  task automatic t_deint(input int k, input int exp_clk, input string req);
    int n;
    n = 0;
    while (!deint_en) @(negedge clk);
    while (deint_en) begin
      n++;
      if (k > 0 && n == 4 * k - 2) cmp_cross = 1'b1;
      @(negedge clk);
    end
    cmp_cross = 1'b0;
    chk(n == exp_clk, req, "deintegrate clocks", n, exp_clk);
    chk(phases() == 8, "R1", "integrator zero after deintegrate", phases(), 8);
  endtask

  task automatic t_iz();
    int n;
    n = 0;
    while (!iz_en) @(negedge clk);
    while (iz_en) begin n++; @(negedge clk); end
    chk(n == 4 * IZ_T, "R2", "integrator zero clocks", n, 4 * IZ_T);
    chk(phases() == 1, "R1", "auto zero after integrator zero", phases(), 1);
  endtask

  task automatic t_read(input int exp_word, input logic exp_ovf, input string req);
    int n, bits;
    logic [23:0] word;
    logic prev;
    bit dv_ok;
    while (!az_en) @(negedge clk);
    chk(data_ready_n == 1'b0, "R7", "strobe low at auto zero start", data_ready_n, 0);
    chk(ser_clk == 1'b0, "R8", "bit clock falls at auto zero start", ser_clk, 0);
    n = 0; bits = 0; word = '0; prev = 1'b0; dv_ok = 1;
    while (az_en) begin
      n++;
      if (data_ready_n) dv_ok = 0;
      if (!prev && ser_clk && bits < 24) begin
        word = {word[22:0], ser_data};
        bits++;
      end
      prev = ser_clk;
      @(negedge clk);
    end
    chk(n == 4 * AZ_T, "R2", "auto zero clocks", n, 4 * AZ_T);
    chk(dv_ok, "R7", "strobe low through auto zero", dv_ok, 1);
    chk(data_ready_n == 1'b1, "R7", "strobe high after auto zero", data_ready_n, 1);
    chk(bits == 24, "R8", "bit count", bits, 24);
    chk(word == 24'(exp_word), req, "shifted result", int'(word), exp_word);
    chk(result_ovf == exp_ovf, "R6", "overflow flag", result_ovf, exp_ovf);
  endtask

  task automatic t_oe();
    sel_n = 1'b1;
    #1;
    chk(out_en == 1'b1, "R9", "pad enable before clock", out_en, 1);
    @(negedge clk);
    chk(out_en == 1'b0, "R9", "pad enable off after deselect", out_en, 0);
    sel_n = 1'b0;
    @(negedge clk);
    chk(out_en == 1'b1, "R9", "pad enable back on", out_en, 1);
  endtask

  task automatic t_sleep();
    int n;
    bit quiet;
    sleep_req = 1'b1;
    n = 0;
    while (!conv_pd && n < 20) begin @(negedge clk); n++; end
    chk(n >= 3 && n <= 6, "R11", "power-down latency", n, 6);
    chk(phases() == 0 && !osc_en, "R11", "halted outputs", {phases(), osc_en}, 0);
    quiet = 1;
    repeat (40) begin
      @(negedge clk);
      if (phases() != 0 || !conv_pd || osc_en) quiet = 0;
    end
    chk(quiet, "R11", "stays powered down", quiet, 1);
    t_oe();
    sleep_req = 1'b0;
  endtask

  initial begin
    #400000;
    chk(0, "WATCHDOG", "run did not finish", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_int(exp_ticks(6), 0, 3'b000, "R3");
    t_deint(10, 40, "R5");
    t_iz();
    tint_sel = 3'b000;
    t_read(9, 1'b0, "R5");
    t_int(exp_ticks(1), 0, 3'b000, "R3");
    t_deint(0, 8 * exp_ticks(1), "R6");
    t_iz();
    tint_sel = 3'b010;
    t_read(2 * exp_ticks(1), 1'b1, "R6");
    t_int(exp_ticks(3), 20, 3'b111, "R4");
    t_deint(5, 20, "R5");
    t_iz();
    t_read(4, 1'b0, "R6");
    t_int(exp_ticks(18), 0, 3'b111, "R4");
    t_deint(3, 12, "R5");
    t_iz();
    t_read(2, 1'b0, "R5");
    t_sleep();
    t_read(2, 1'b0, "R11");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule